// File: doc/BRIEF.md
# Reservation Station Wakeup and Select

This block is a small pool of scheduling slots placed between a rename stage and two execution units, one adder and one multiplier. The rename stage writes a renamed instruction into a free slot. The instruction carries an opcode, a destination tag and two source operands. Each operand arrives either as a value or as the tag of the instruction that will produce it. Slots with a missing operand watch a single result broadcast bus. When the bus tag equals the operand's tag, the slot takes the bus value.

A slot whose two operands both hold values becomes eligible to issue. In each cycle the block offers at most one add-class instruction and at most one multiply-class instruction to the execution units. When more than one slot is eligible for the same unit, the slot that was allocated earliest wins. The block raises `full` when it has no free slot, and the rename stage must hold back while `full` is high.

Each slot runs a three-state machine:
- **ST_FREE** (empty) moves to ST_WAIT or ST_READY on `load`.
- **ST_WAIT** (an operand is missing) moves to ST_READY once both operands are captured.
- **ST_READY** (eligible) moves to ST_FREE when the slot is granted to its unit.

Top module: `rs_wakeup_select`

## Requirements
- R1: A write with `alloc_valid` high is taken only when `full` is low in that cycle. A write attempted while `full` is high creates no slot and is never issued.
- R2: Each source comes with a ready flag (`alloc_aok` / `alloc_bok`). When the flag is 1 the value field is used. When the flag is 0 the tag field names the producer.
- R3: A slot waiting on a source compares that source's tag with `bcast_tag` whenever `bcast_valid` is high. On a match it stores `bcast_val` as the operand and marks the operand valid.
- R4: A slot issues only when both operands are valid. It can first issue in the cycle after the clock edge at which its last operand became valid.
- R5: `alloc_op[OP_W-1]` selects the unit: 0 sends the instruction to the adder, 1 to the multiplier. At most one instruction per unit is presented per cycle. While a unit's valid output is high, its op, dst, a and b outputs carry the selected slot's opcode, destination tag, first operand and second operand.
- R6: Among eligible slots of the same class, the slot allocated earliest is presented.
- R7: If a slot is allocated in the same cycle as a broadcast whose tag matches one of its pending sources, it takes the broadcast value for that source.
- R8: A presented instruction leaves the pool at the clock edge that ends its issue cycle, and its slot is free from the next cycle on. `full` is 1 exactly when all `N_SLOTS` slots are occupied.
- R9: After reset all slots are free, `full` is 0 and neither unit output is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Rename stage offers an instruction |
| alloc_op | input | OP_W | Opcode; MSB selects the unit |
| alloc_dst | input | TAG_W | Destination tag |
| alloc_aok | input | 1 | First source already has a value |
| alloc_atag | input | TAG_W | First source producer tag |
| alloc_aval | input | DATA_W | First source value |
| alloc_bok | input | 1 | Second source already has a value |
| alloc_btag | input | TAG_W | Second source producer tag |
| alloc_bval | input | DATA_W | Second source value |
| full | output | 1 | No free slot |
| bcast_valid | input | 1 | Result broadcast present |
| bcast_tag | input | TAG_W | Tag of the broadcast result |
| bcast_val | input | DATA_W | Broadcast result value |
| add_issue_valid | output | 1 | Adder instruction presented |
| add_op | output | OP_W | Adder opcode |
| add_dst | output | TAG_W | Adder destination tag |
| add_a | output | DATA_W | Adder first operand |
| add_b | output | DATA_W | Adder second operand |
| mul_issue_valid | output | 1 | Multiplier instruction presented |
| mul_op | output | OP_W | Multiplier opcode |
| mul_dst | output | TAG_W | Multiplier destination tag |
| mul_a | output | DATA_W | Multiplier first operand |
| mul_b | output | DATA_W | Multiplier second operand |

## Verification
A slot machine stuck in the wrong state shows up within a cycle. Either the instruction never appears on its unit's outputs, or it appears a second time on the cycle after its issue, or `full` disagrees with the occupancy. A missed or wrong operand capture shows a wrong `a`/`b` value at the issue of that instruction, or a permanently waiting instruction. A corrupted age order shows up as the wrong destination tag in the first cycle in which two instructions of one class are eligible together. The bench model predicts every output in every cycle, so each such fault is reported in the cycle it first reaches the ports.

// File: rtl/rs_pkg.sv
package rs_pkg;
    typedef enum logic [1:0] {
        ST_FREE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_READY = 2'd2
    } slot_state_e;
endpackage

// File: rtl/rs_slot.sv
module rs_slot
    import rs_pkg::*;
#(
    parameter int OP_W   = 3,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [OP_W-1:0]   ld_op,
    input  logic [TAG_W-1:0]  ld_dst,
    input  logic              ld_a_ok,
    input  logic [TAG_W-1:0]  ld_a_tag,
    input  logic [DATA_W-1:0] ld_a_val,
    input  logic              ld_b_ok,
    input  logic [TAG_W-1:0]  ld_b_tag,
    input  logic [DATA_W-1:0] ld_b_val,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_val,
    input  logic              fire,
    output slot_state_e       state,
    output logic [OP_W-1:0]   op,
    output logic [TAG_W-1:0]  dst,
    output logic [DATA_W-1:0] a_val,
    output logic [DATA_W-1:0] b_val
);
    slot_state_e       state_q, state_d;
    logic [OP_W-1:0]   op_q;
    logic [TAG_W-1:0]  dst_q, a_tag_q, b_tag_q;
    logic [DATA_W-1:0] a_val_q, b_val_q;
    logic              a_ok_q, b_ok_q;

    // operand capture at allocation time (same-cycle wakeup, R7)
    logic a_snoop_ld, b_snoop_ld, a_ok_ld, b_ok_ld;
    assign a_snoop_ld = !ld_a_ok && bc_valid && (bc_tag == ld_a_tag);
    assign b_snoop_ld = !ld_b_ok && bc_valid && (bc_tag == ld_b_tag);
    assign a_ok_ld    = ld_a_ok || a_snoop_ld;
    assign b_ok_ld    = ld_b_ok || b_snoop_ld;

    // operand capture while waiting (R3)
    logic a_snoop, b_snoop;
    assign a_snoop = (state_q == ST_WAIT) && !a_ok_q && bc_valid && (bc_tag == a_tag_q);
    assign b_snoop = (state_q == ST_WAIT) && !b_ok_q && bc_valid && (bc_tag == b_tag_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FREE:  if (load) state_d = (a_ok_ld && b_ok_ld) ? ST_READY : ST_WAIT;
            ST_WAIT:  if ((a_ok_q || a_snoop) && (b_ok_q || b_snoop)) state_d = ST_READY;
            ST_READY: if (fire) state_d = ST_FREE;
            default:  state_d = ST_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FREE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= '0;
            dst_q   <= '0;
            a_ok_q  <= 1'b0;
            b_ok_q  <= 1'b0;
            a_tag_q <= '0;
            b_tag_q <= '0;
            a_val_q <= '0;
            b_val_q <= '0;
        end else if (load) begin
            op_q    <= ld_op;
            dst_q   <= ld_dst;
            a_ok_q  <= a_ok_ld;
            b_ok_q  <= b_ok_ld;
            a_tag_q <= ld_a_tag;
            b_tag_q <= ld_b_tag;
            a_val_q <= a_snoop_ld ? bc_val : ld_a_val;
            b_val_q <= b_snoop_ld ? bc_val : ld_b_val;
        end else begin
            if (a_snoop) begin
                a_ok_q  <= 1'b1;
                a_val_q <= bc_val;
            end
            if (b_snoop) begin
                b_ok_q  <= 1'b1;
                b_val_q <= bc_val;
            end
        end
    end

    assign state = state_q;
    assign op    = op_q;
    assign dst   = dst_q;
    assign a_val = a_val_q;
    assign b_val = b_val_q;

    assert_capture_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !a_ok_q && bc_valid && bc_tag == a_tag_q)
        |=> (a_ok_q && a_val_q == $past(bc_val)));

    assert_fire_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (state_q == ST_READY));

    assert_fire_frees_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (state_q == ST_FREE));
endmodule

// File: rtl/rs_age.sv
module rs_age #(
    parameter int N = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        alloc_oh,
    output logic [N-1:0][N-1:0] older
);
    // older[i][j] = 1 : slot i was allocated before slot j
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            older <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                for (int j = 0; j < N; j++) begin
                    if (alloc_oh[i])      older[i][j] <= 1'b0;
                    else if (alloc_oh[j]) older[i][j] <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rs_pick.sv
module rs_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0]        req,
    input  logic [N-1:0][N-1:0] older,
    output logic [N-1:0]        gnt
);
    for (genvar i = 0; i < N; i++) begin : g_row
        logic win;
        always_comb begin
            win = req[i];
            for (int j = 0; j < N; j++) begin
                if (j != i && req[j] && !older[i][j]) win = 1'b0;
            end
        end
        assign gnt[i] = win;
    end
endmodule

// File: rtl/rs_wakeup_select.sv
module rs_wakeup_select
    import rs_pkg::*;
#(
    parameter int N_SLOTS = 4,
    parameter int OP_W    = 3,
    parameter int TAG_W   = 4,
    parameter int DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [OP_W-1:0]   alloc_op,
    input  logic [TAG_W-1:0]  alloc_dst,
    input  logic              alloc_aok,
    input  logic [TAG_W-1:0]  alloc_atag,
    input  logic [DATA_W-1:0] alloc_aval,
    input  logic              alloc_bok,
    input  logic [TAG_W-1:0]  alloc_btag,
    input  logic [DATA_W-1:0] alloc_bval,
    output logic              full,
    input  logic              bcast_valid,
    input  logic [TAG_W-1:0]  bcast_tag,
    input  logic [DATA_W-1:0] bcast_val,
    output logic              add_issue_valid,
    output logic [OP_W-1:0]   add_op,
    output logic [TAG_W-1:0]  add_dst,
    output logic [DATA_W-1:0] add_a,
    output logic [DATA_W-1:0] add_b,
    output logic              mul_issue_valid,
    output logic [OP_W-1:0]   mul_op,
    output logic [TAG_W-1:0]  mul_dst,
    output logic [DATA_W-1:0] mul_a,
    output logic [DATA_W-1:0] mul_b
);
    localparam int CLS_BIT = OP_W - 1;

    slot_state_e       s_state [N_SLOTS];
    logic [OP_W-1:0]   s_op    [N_SLOTS];
    logic [TAG_W-1:0]  s_dst   [N_SLOTS];
    logic [DATA_W-1:0] s_a     [N_SLOTS];
    logic [DATA_W-1:0] s_b     [N_SLOTS];

    logic [N_SLOTS-1:0] free_v, load_oh, add_req, mul_req, add_gnt, mul_gnt;
    logic [N_SLOTS-1:0][N_SLOTS-1:0] older;

    for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
        assign free_v[i]  = (s_state[i] == ST_FREE);
        assign add_req[i] = (s_state[i] == ST_READY) && !s_op[i][CLS_BIT];
        assign mul_req[i] = (s_state[i] == ST_READY) &&  s_op[i][CLS_BIT];

        rs_slot #(.OP_W(OP_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load_oh[i]),
            .ld_op    (alloc_op),
            .ld_dst   (alloc_dst),
            .ld_a_ok  (alloc_aok),
            .ld_a_tag (alloc_atag),
            .ld_a_val (alloc_aval),
            .ld_b_ok  (alloc_bok),
            .ld_b_tag (alloc_btag),
            .ld_b_val (alloc_bval),
            .bc_valid (bcast_valid),
            .bc_tag   (bcast_tag),
            .bc_val   (bcast_val),
            .fire     (add_gnt[i] | mul_gnt[i]),
            .state    (s_state[i]),
            .op       (s_op[i]),
            .dst      (s_dst[i]),
            .a_val    (s_a[i]),
            .b_val    (s_b[i])
        );
    end

    assign full = ~|free_v;

    // lowest-index free slot takes the new instruction
    always_comb begin
        logic found;
        found   = 1'b0;
        load_oh = '0;
        for (int i = 0; i < N_SLOTS; i++) begin
            if (free_v[i] && !found) begin
                found      = 1'b1;
                load_oh[i] = alloc_valid;
            end
        end
    end

    rs_age #(.N(N_SLOTS)) u_age (
        .clk      (clk),
        .rst_n    (rst_n),
        .alloc_oh (load_oh),
        .older    (older)
    );

    rs_pick #(.N(N_SLOTS)) u_pick_add (.req(add_req), .older(older), .gnt(add_gnt));
    rs_pick #(.N(N_SLOTS)) u_pick_mul (.req(mul_req), .older(older), .gnt(mul_gnt));

    always_comb begin
        add_issue_valid = |add_gnt;
        mul_issue_valid = |mul_gnt;
        add_op = '0; add_dst = '0; add_a = '0; add_b = '0;
        mul_op = '0; mul_dst = '0; mul_a = '0; mul_b = '0;
        for (int i = 0; i < N_SLOTS; i++) begin
            if (add_gnt[i]) begin
                add_op  |= s_op[i];
                add_dst |= s_dst[i];
                add_a   |= s_a[i];
                add_b   |= s_b[i];
            end
            if (mul_gnt[i]) begin
                mul_op  |= s_op[i];
                mul_dst |= s_dst[i];
                mul_a   |= s_a[i];
                mul_b   |= s_b[i];
            end
        end
    end

    assert_single_add_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(add_gnt));

    assert_single_mul_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mul_gnt));

    assert_add_class_R5: assert property (@(posedge clk) disable iff (!rst_n)
        add_issue_valid |-> !add_op[CLS_BIT]);

    assert_full_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !add_issue_valid && !mul_issue_valid) |=> full);
endmodule

// File: tb/sim_rs_wakeup_select.sv
module sim_rs_wakeup_select;
    localparam int N  = 4;
    localparam int OW = 3;
    localparam int TW = 4;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;  // 125 MHz

    logic          alloc_valid = 0, alloc_aok = 0, alloc_bok = 0, bcast_valid = 0;
    logic [OW-1:0] alloc_op = 0;
    logic [TW-1:0] alloc_dst = 0, alloc_atag = 0, alloc_btag = 0, bcast_tag = 0;
    logic [DW-1:0] alloc_aval = 0, alloc_bval = 0, bcast_val = 0;
    logic          full, add_issue_valid, mul_issue_valid;
    logic [OW-1:0] add_op, mul_op;
    logic [TW-1:0] add_dst, mul_dst;
    logic [DW-1:0] add_a, add_b, mul_a, mul_b;

    rs_wakeup_select #(.N_SLOTS(N), .OP_W(OW), .TAG_W(TW), .DATA_W(DW)) u0 (.*);

    // behavioural reference: a bag of entries ordered by an allocation counter
    bit          m_busy [N];
    bit          m_aok  [N];
    bit          m_bok  [N];
    int          m_seq  [N];
    logic [OW-1:0] m_op [N];
    logic [TW-1:0] m_dst[N], m_atag[N], m_btag[N];
    logic [DW-1:0] m_a  [N], m_b[N];
    int          seq_ctr = 0;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    function automatic int m_count();
        int c = 0;
        for (int i = 0; i < N; i++) if (m_busy[i]) c++;
        return c;
    endfunction

    function automatic int m_pick(bit mul);
        int best = -1;
        for (int i = 0; i < N; i++)
            if (m_busy[i] && m_aok[i] && m_bok[i] && (m_op[i][OW-1] == mul))
                if (best < 0 || m_seq[i] < m_seq[best]) best = i;
        return best;
    endfunction

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic compare();
        int pa = m_pick(1'b0);
        int pm = m_pick(1'b1);
        longint e;
        longint a;
        chk(full == (m_count() == N), "R1 R8 full flag", full, m_count() == N);
        if (pa < 0) begin
            chk(!add_issue_valid, "R4 R5 adder idle", add_issue_valid, 0);
        end else begin
            e = {1'b1, m_op[pa], m_dst[pa], m_a[pa], m_b[pa]};
            a = {add_issue_valid, add_op, add_dst, add_a, add_b};
            chk(a == e, "R3 R4 R5 R6 adder issue", a, e);
        end
        if (pm < 0) begin
            chk(!mul_issue_valid, "R4 R5 multiplier idle", mul_issue_valid, 0);
        end else begin
            e = {1'b1, m_op[pm], m_dst[pm], m_a[pm], m_b[pm]};
            a = {mul_issue_valid, mul_op, mul_dst, mul_a, mul_b};
            chk(a == e, "R3 R4 R5 R6 multiplier issue", a, e);
        end
    endtask

    task automatic model_edge();
        int  pa = m_pick(1'b0);
        int  pm = m_pick(1'b1);
        bit  was_full = (m_count() == N);
        if (pa >= 0) m_busy[pa] = 0;  // R8
        if (pm >= 0) m_busy[pm] = 0;
        if (bcast_valid) begin
            for (int i = 0; i < N; i++) begin
                if (m_busy[i] && !m_aok[i] && m_atag[i] == bcast_tag) begin m_aok[i] = 1; m_a[i] = bcast_val; end
                if (m_busy[i] && !m_bok[i] && m_btag[i] == bcast_tag) begin m_bok[i] = 1; m_b[i] = bcast_val; end
            end
        end
        if (alloc_valid && !was_full) begin
            for (int i = 0; i < N; i++) begin
                if (!m_busy[i]) begin
                    m_busy[i] = 1; m_op[i] = alloc_op; m_dst[i] = alloc_dst;
                    m_seq[i] = seq_ctr++;
                    m_atag[i] = alloc_atag; m_btag[i] = alloc_btag;
                    m_aok[i] = alloc_aok; m_a[i] = alloc_aval;
                    m_bok[i] = alloc_bok; m_b[i] = alloc_bval;
                    if (!alloc_aok && bcast_valid && alloc_atag == bcast_tag) begin m_aok[i] = 1; m_a[i] = bcast_val; end
                    if (!alloc_bok && bcast_valid && alloc_btag == bcast_tag) begin m_bok[i] = 1; m_b[i] = bcast_val; end
                    break;
                end
            end
        end
    endtask

    task automatic drive(input bit av, input logic [OW-1:0] op, input logic [TW-1:0] dst,
                         input bit aok, input logic [TW-1:0] atag, input logic [DW-1:0] aval,
                         input bit bok, input logic [TW-1:0] btag, input logic [DW-1:0] bval,
                         input bit bv, input logic [TW-1:0] btg, input logic [DW-1:0] bvl);
        alloc_valid = av; alloc_op = op; alloc_dst = dst;
        alloc_aok = aok; alloc_atag = atag; alloc_aval = aval;
        alloc_bok = bok; alloc_btag = btag; alloc_bval = bval;
        bcast_valid = bv; bcast_tag = btg; bcast_val = bvl;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic idle();
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R8 watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) m_busy[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        chk(!full && !add_issue_valid && !mul_issue_valid, "R9 reset state",
            {full, add_issue_valid, mul_issue_valid}, 0);
        compare();

        // R2 R4: both sources carry values, issues next cycle
        drive(1, 3'b001, 9, 1, 0, 16'h0011, 1, 0, 16'h0022, 0, 0, 0);
        idle();

        // R5: one add and one multiply wait on tag 6, released together
        drive(1, 3'b101, 2, 0, 6, 0, 1, 0, 16'h0003, 0, 0, 0);
        drive(1, 3'b010, 3, 1, 0, 16'h0007, 0, 6, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 6, 16'h0abc);
        idle(); idle();

        // R6: three adds wake in one cycle, issued oldest first
        drive(1, 3'b000, 10, 0, 5, 0, 1, 0, 16'h0001, 0, 0, 0);
        drive(1, 3'b001, 11, 0, 5, 0, 1, 0, 16'h0002, 0, 0, 0);
        drive(1, 3'b011, 12, 1, 0, 16'h0003, 0, 5, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 5, 16'h5555);
        idle(); idle(); idle();

        // R7: allocation meets matching broadcast in the same cycle
        drive(1, 3'b100, 7, 0, 3, 0, 1, 0, 16'h0009, 1, 3, 16'h3333);
        idle(); idle();

        // R1 R8: fill the pool, try one more, then drain
        for (int k = 0; k < N; k++)
            drive(1, 3'b001, 4'(k), 0, 4'(12 + k), 0, 1, 0, 16'(k), 0, 0, 0);
        drive(1, 3'b000, 15, 1, 0, 16'hdead, 1, 0, 16'hbeef, 0, 0, 0);
        for (int k = 0; k < N; k++)
            drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 4'(12 + k), 16'(100 + k));
        idle(); idle();

        // mixed traffic
        for (int c = 0; c < 3000; c++) begin
            drive(($urandom % 2) == 1, OW'($urandom), TW'($urandom),
                  ($urandom % 2) == 1, TW'($urandom % 8), DW'($urandom),
                  ($urandom % 2) == 1, TW'($urandom % 8), DW'($urandom),
                  ($urandom % 5) < 2, TW'($urandom % 8), DW'($urandom));
        end
        for (int c = 0; c < 20; c++)
            drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, TW'(c % 8), DW'(c));

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule